// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block keeps the transmit error count of a CAN node and decides when the node must drop off the bus and when it may come back. Error events from the protocol engine raise or lower the count. Once the count passes its limit, the node goes bus-off and stops driving the bus. It then watches the sampled receive bit stream, one bit per bit-time strobe, and counts how many separate runs of consecutive recessive bits it sees.

When the required number of runs has been seen, the recovery sequence is complete. A configuration bit then selects what happens next. In automatic mode, the node rejoins the bus by itself. In software mode, it waits for a recovery request. A request that arrives early is held until the sequence finishes. When the node leaves bus-off, the error count restarts from zero.

Top module: `can_busoff_ctrl`

## Requirements
- R1: After reset, `bus_off` is 0, `node_active` is 1, `recovery_done` is 0 and `tec_value` is 0.
- R2: While the node is active, `err_inc` adds 8 to `tec_value` and `err_dec` subtracts 1. When both are high in the same cycle, the net change is +7. A decrement alone at a count of 0 leaves the count at 0. Each change shows on `tec_value` one cycle after the event.
- R3: One cycle after `tec_value` shows a value above 255, `bus_off` goes to 1 and `node_active` goes to 0. A value of exactly 255 never causes bus-off.
- R4: While `bus_off` is 1, `err_inc` and `err_dec` have no effect, and `tec_value` keeps the value it had on entry.
- R5: While the node is bus-off, each cycle with `bit_strobe`=1 and `rx_bit`=1 (recessive) extends the current run. A strobed `rx_bit`=0 (dominant) restarts the current run but keeps the number of runs already completed. Cycles with `bit_strobe`=0 are ignored.
- R6: `recovery_done` goes to 1 in the cycle after the last bit of the 128th completed run of 11 recessive bits. It stays at 1 until the node leaves bus-off, and it is 0 while the node is active.
- R7: With `auto_recover`=1, `bus_off` falls one cycle after `recovery_done` rises, and `tec_value` reads 0 from that same cycle.
- R8: With `auto_recover`=0 and no earlier request, the node stays bus-off after the sequence completes. It leaves bus-off in the cycle after a cycle in which `sw_recover_req`=1, and `tec_value` then reads 0.
- R9: A `sw_recover_req` pulse received while bus-off, before the sequence is complete, is held as pending. The node then leaves bus-off one cycle after `recovery_done` rises, just as in automatic mode.
- R10: A `sw_recover_req` received while the node is active has no effect. A pending request is discarded when the node leaves bus-off.
- R11: `node_active` is 0 for the whole time that `bus_off` is 1, so the node does not transmit while bus-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_inc | input | 1 | Transmit error event (+8) |
| err_dec | input | 1 | Successful transmit event (-1) |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| bit_strobe | input | 1 | One-cycle pulse marking a valid `rx_bit` |
| auto_recover | input | 1 | 1 = rejoin automatically, 0 = wait for software |
| sw_recover_req | input | 1 | Software recovery request |
| bus_off | output | 1 | Node is in the bus-off state |
| node_active | output | 1 | Node may take part on the bus |
| recovery_done | output | 1 | Recovery sequence has been observed |
| tec_value | output | 9 | Transmit error count |

## Verification
An error event shows on `tec_value` one cycle later. `bus_off` follows a count above the limit by one more cycle. `recovery_done` rises one cycle after the strobe that completes the last run, and the exit happens one cycle after `recovery_done` rises, or one cycle after the request in software mode. The bench drives inputs just after a rising edge and reads the outputs at that same point, one edge later. Because of this, each result is read exactly in the cycle it is due. The bench also reads it one cycle earlier where the requirement forbids an early change, such as a count of 255 or 127 runs plus an interrupted one.

// File: rtl/can_bo_pkg.sv
package can_bo_pkg;
  typedef enum logic {
    NODE_ACTIVE = 1'b0,
    NODE_BUSOFF = 1'b1
  } node_state_e;
endpackage

// File: rtl/can_tec_counter.sv
// Transmit error count: +INC_STEP per error, -1 per success, floor at zero.
// Frozen while held or once the count passes LIMIT; cleared on recovery.
module can_tec_counter #(
  parameter int INC_STEP = 8,
  parameter int LIMIT    = 255,
  parameter int W        = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  input  logic         hold,
  input  logic         clear,
  output logic [W-1:0] tec,
  output logic         over
);
  logic [W-1:0] sum;
  logic [W-1:0] nxt;

  always_comb begin
    sum = tec + (inc ? W'(INC_STEP) : '0);
    nxt = (dec && (sum != '0)) ? sum - W'(1) : sum;
  end

  assign over = (tec > W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clear) tec <= '0;
    else if (!hold && !over) tec <= nxt;
  end
endmodule

// File: rtl/can_recess_runs.sv
// Counts complete runs of RUN_LEN strobed recessive bits; raises done after RUN_NUM.
module can_recess_runs #(
  parameter int RUN_LEN = 11,
  parameter int RUN_NUM = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic clear,
  input  logic strobe,
  input  logic rx,
  output logic done
);
  localparam int LEN_W = $clog2(RUN_LEN + 1);
  localparam int NUM_W = $clog2(RUN_NUM + 1);

  logic [LEN_W-1:0] len_q;
  logic [NUM_W-1:0] num_q;
  logic             run_end;
  logic             last_run;

  assign run_end  = (len_q == LEN_W'(RUN_LEN - 1));
  assign last_run = (num_q == NUM_W'(RUN_NUM - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      len_q <= '0;
      num_q <= '0;
      done  <= 1'b0;
    end else if (enable && strobe && !done) begin
      if (!rx) begin
        len_q <= '0;
      end else if (run_end) begin
        len_q <= '0;
        num_q <= num_q + NUM_W'(1);
        if (last_run) done <= 1'b1;
      end else begin
        len_q <= len_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/can_busoff_fsm.sv
// Node state, pending software request and registered state outputs.
module can_busoff_fsm
  import can_bo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic over,
  input  logic seq_done,
  input  logic auto_mode,
  input  logic sw_req,
  output logic leave,
  output logic bus_off_q,
  output logic active_q
);
  node_state_e state_q, state_d;
  logic        pending_q;

  always_comb begin
    leave   = (state_q == NODE_BUSOFF) && seq_done && (auto_mode || pending_q || sw_req);
    state_d = state_q;
    if (state_q == NODE_ACTIVE && over) state_d = NODE_BUSOFF;
    else if (leave)                     state_d = NODE_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= NODE_ACTIVE;
      bus_off_q <= 1'b0;
      active_q  <= 1'b1;
      pending_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      bus_off_q <= (state_d == NODE_BUSOFF);
      active_q  <= (state_d == NODE_ACTIVE);
      if (leave) pending_q <= 1'b0;
      else if (state_q == NODE_BUSOFF && sw_req) pending_q <= 1'b1;
    end
  end
endmodule

// File: rtl/can_busoff_ctrl.sv
module can_busoff_ctrl #(
  parameter int INC_STEP     = 8,
  parameter int BUSOFF_LIMIT = 255,
  parameter int RUN_LEN      = 11,
  parameter int RUN_NUM      = 128,
  localparam int TEC_W       = $clog2(BUSOFF_LIMIT + INC_STEP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_inc,
  input  logic             err_dec,
  input  logic             rx_bit,
  input  logic             bit_strobe,
  input  logic             auto_recover,
  input  logic             sw_recover_req,
  output logic             bus_off,
  output logic             node_active,
  output logic             recovery_done,
  output logic [TEC_W-1:0] tec_value
);
  logic over;
  logic leave;

  can_tec_counter #(.INC_STEP(INC_STEP), .LIMIT(BUSOFF_LIMIT), .W(TEC_W)) u_tec (
    .clk(clk), .rst(rst), .inc(err_inc), .dec(err_dec),
    .hold(bus_off), .clear(leave), .tec(tec_value), .over(over)
  );

  can_recess_runs #(.RUN_LEN(RUN_LEN), .RUN_NUM(RUN_NUM)) u_runs (
    .clk(clk), .rst(rst), .enable(bus_off), .clear(leave),
    .strobe(bit_strobe), .rx(rx_bit), .done(recovery_done)
  );

  can_busoff_fsm u_fsm (
    .clk(clk), .rst(rst), .over(over), .seq_done(recovery_done),
    .auto_mode(auto_recover), .sw_req(sw_recover_req), .leave(leave),
    .bus_off_q(bus_off), .active_q(node_active)
  );
endmodule

// File: rtl/can_busoff_chk.sv
module can_busoff_chk #(
  parameter int INC_STEP = 8,
  parameter int LIMIT    = 255,
  localparam int W       = $clog2(LIMIT + INC_STEP + 1)
) (
  input logic         clk,
  input logic         rst,
  input logic         err_inc,
  input logic         auto_recover,
  input logic         bus_off,
  input logic         recovery_done,
  input logic [W-1:0] tec_value
);
  p_enter_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_off && tec_value > W'(LIMIT)) |=> bus_off);

  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_off && !recovery_done) |=> $stable(tec_value));

  p_exit_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_off) |-> $past(recovery_done));

  p_exit_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_off) |-> (tec_value == '0));

  p_auto_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (recovery_done && auto_recover) |=> !bus_off);

  p_floor_r2: assert property (@(posedge clk) disable iff (rst)
    (!bus_off && tec_value == '0 && !err_inc) |=> (tec_value == '0));
endmodule

bind can_busoff_ctrl can_busoff_chk #(.INC_STEP(INC_STEP), .LIMIT(BUSOFF_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .err_inc(err_inc), .auto_recover(auto_recover),
  .bus_off(bus_off), .recovery_done(recovery_done), .tec_value(tec_value)
);

// File: tb/tb_can_busoff_ctrl.sv
`timescale 1ns/1ps
module tb_can_busoff_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_inc = 1'b0, err_dec = 1'b0, rx_bit = 1'b1, bit_strobe = 1'b0;
  logic auto_recover = 1'b1, sw_recover_req = 1'b0;
  logic bus_off, node_active, recovery_done;
  logic [8:0] tec_value;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_busoff_ctrl dut (
    .clk(clk), .rst(rst), .err_inc(err_inc), .err_dec(err_dec),
    .rx_bit(rx_bit), .bit_strobe(bit_strobe), .auto_recover(auto_recover),
    .sw_recover_req(sw_recover_req), .bus_off(bus_off), .node_active(node_active),
    .recovery_done(recovery_done), .tec_value(tec_value)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b;
    bit_strobe = 1'b1;
    step();
    bit_strobe = 1'b0;
    rx_bit = 1'b1;
  endtask

  task automatic send_runs(input int n);
    for (int r = 0; r < n; r++)
      for (int b = 0; b < 11; b++) send_bit(1'b1);
  endtask

  task automatic enter_busoff();
    err_inc = 1'b1;
    repeat (33) step();
    err_inc = 1'b0;
    step();
    chk("R3 bus_off after overflow", bus_off, 1);
    chk("R11 node_active while bus-off", node_active, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 bus_off", bus_off, 0);
    chk("R1 node_active", node_active, 1);
    chk("R1 recovery_done", recovery_done, 0);
    chk("R1 tec", tec_value, 0);

    // R2: arithmetic sweep against a model, starting with decrements at zero
    begin
      int m = 0;
      for (int i = 0; i < 200; i++) begin
        logic a, d;
        a = (i >= 4) && (i % 5 == 0);
        d = (i < 4) || (i % 2 == 0);
        err_inc = a;
        err_dec = d;
        step();
        if (a) m = m + 8;
        if (d && m != 0) m = m - 1;
        chk("R2 tec sweep", tec_value, m);
      end
      err_inc = 1'b0;
      err_dec = 1'b0;
      chk("R3 no bus-off below limit", bus_off, 0);
    end

    // R3: exactly 255 stays active; 263 enters bus-off one cycle later
    do_reset();
    err_inc = 1'b1;
    repeat (31) step();
    chk("R2 tec after 31 errors", tec_value, 248);
    err_dec = 1'b1;
    step();
    err_inc = 1'b0;
    err_dec = 1'b0;
    chk("R2 combined +7", tec_value, 255);
    repeat (3) step();
    chk("R3 255 not bus-off", bus_off, 0);
    err_inc = 1'b1;
    step();
    err_inc = 1'b0;
    chk("R2 tec 263", tec_value, 263);
    chk("R3 bus_off not yet", bus_off, 0);
    step();
    chk("R3 bus_off set", bus_off, 1);
    chk("R11 node_active low", node_active, 0);

    // R4: events ignored while bus-off
    err_inc = 1'b1;
    step();
    err_inc = 1'b0;
    err_dec = 1'b1;
    step();
    err_dec = 1'b0;
    chk("R4 tec frozen", tec_value, 263);

    // R5/R6/R7: automatic recovery with an interrupted run and unstrobed cycles
    auto_recover = 1'b1;
    send_runs(127);
    for (int b = 0; b < 10; b++) send_bit(1'b1);
    send_bit(1'b0);
    for (int b = 0; b < 10; b++) send_bit(1'b1);
    rx_bit = 1'b1;
    repeat (3) step();
    chk("R5 run restart and strobe gating", recovery_done, 0);
    chk("R11 still bus-off", bus_off, 1);
    send_bit(1'b1);
    chk("R6 done after 128 runs", recovery_done, 1);
    chk("R6 still bus-off at done", bus_off, 1);
    step();
    chk("R7 auto exit", bus_off, 0);
    chk("R7 tec zero", tec_value, 0);
    chk("R7 node_active", node_active, 1);
    chk("R6 done cleared", recovery_done, 0);

    // R10: request while active is ignored; R8: manual recovery waits
    auto_recover = 1'b0;
    sw_recover_req = 1'b1;
    step();
    sw_recover_req = 1'b0;
    chk("R10 request while active", bus_off, 0);
    enter_busoff();
    send_runs(128);
    chk("R6 manual done", recovery_done, 1);
    repeat (5) step();
    chk("R8 waits for request", bus_off, 1);
    chk("R6 done held", recovery_done, 1);
    sw_recover_req = 1'b1;
    step();
    sw_recover_req = 1'b0;
    chk("R8 exit on request", bus_off, 0);
    chk("R8 tec zero", tec_value, 0);

    // R9: early request is latched
    enter_busoff();
    sw_recover_req = 1'b1;
    step();
    sw_recover_req = 1'b0;
    send_runs(128);
    chk("R9 done", recovery_done, 1);
    chk("R9 bus-off at done", bus_off, 1);
    step();
    chk("R9 exit from pending", bus_off, 0);

    // R10: pending was discarded on exit
    enter_busoff();
    send_runs(128);
    repeat (3) step();
    chk("R10 pending cleared", bus_off, 1);
    sw_recover_req = 1'b1;
    step();
    sw_recover_req = 1'b0;
    chk("R8 final exit", bus_off, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule